// File: doc/BRIEF.md
# Converter Processor Bus Interface

This block connects the sequencer of an 8-bit converter to a plain processor read bus. It takes the active-low chip select and read strobes (`csN`, `rdN`) and turns them into two things: read cycles, and requests to start a conversion. It holds the output data latch. It drives the data lines together with an enable that stands in for three-state buffers. On the sequencer side it sends a one-clock start pulse and a halt request. In return it receives the sequencer's busy flag and the finished result.

The `modeSel` input chooses between two operating modes:

- **Software-started mode (`modeSel` high).** A read cycle starts a conversion. A processor that can wait keeps the strobes low until the conversion ends, and then sees the new result. A processor that cannot wait makes a short read, gets the previous result, and the conversion starts in the background.
- **Free-running mode (`modeSel` low).** Conversions run back to back and the strobes only read data. When a result arrives while a read is in progress, the latch update and the next conversion are both held back until the read ends.

The strobes are synchronized to the clock before they are used for decisions. The data enable follows the pins directly.

Top module: `conv_bus_if`

## Requirements
- R1: After reset, `dataOe`, `startPulse` and `haltReq` are 0 and the data latch reads 0.
- R2: `dataOe` is 1 exactly while `csN` and `rdN` are both 0, and it follows the pins without a clock. A low `rdN` with `csN` high, or a low `csN` with `rdN` high, enables no output and starts no conversion.
- R3: With `modeSel`=1, a transition of the synchronized select (both strobes low) from inactive to active produces one start pulse when the sequencer is idle. The pulse appears within SYNC_STAGES+1 clocks after the pins go low.
- R4: `startPulse` is exactly one clock wide. It is never asserted while `seqBusy` was high in the previous cycle, or while an issued start has not yet been answered by `seqBusy`.
- R5: The end of a conversion is the first clock edge that samples `seqBusy` low after it was high. In software-started mode `seqResult` is loaded into the latch at that edge. A read held low through the whole conversion therefore shows the new value, and `haltReq` stays 0.
- R6: The data lines always show the latch. A read that starts before or during a conversion returns the previous result. A read during a conversion starts nothing.
- R7: In software-started mode, no start is issued when the strobes are already low at the end-of-conversion edge, or are driven low before any of the next GUARD_CYC clock edges. Strobes driven low later than that start a conversion again.
- R8: With `modeSel`=0, a new start is issued whenever the sequencer is idle and no update is pending, whatever the strobes are doing. Each result is loaded at its end-of-conversion edge.
- R9: With `modeSel`=0, if the synchronized select is active at the end-of-conversion edge, the latch keeps its old value and `haltReq` rises. No start is issued until the select goes inactive. Then the held result is loaded, `haltReq` falls and conversions resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock shared with the sequencer |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| rdN | input | 1 | Read strobe, active low, asynchronous |
| modeSel | input | 1 | 1 = software-started conversions, 0 = free-running |
| seqBusy | input | 1 | High while the sequencer converts |
| seqResult | input | DATA_W | Result offered by the sequencer when busy falls |
| startPulse | output | 1 | One-clock request to begin a conversion |
| haltReq | output | 1 | Holds the sequencer idle during a deferred update |
| dataOut | output | DATA_W | Content of the output data latch |
| dataOe | output | 1 | Enable of the modelled three-state data drivers |

## Verification
Two events can land in the same clock cycle: the end-of-conversion latch load and a newly active select. The bench provokes this by driving the strobes low in the same half-cycle in which the sequencer model drops busy, and again one and two clocks later. In software-started mode the judgement is whether a start pulse appears, while the latch must hold the new result in every case. In free-running mode the bench holds a read across the end of conversion. It then checks that the latch keeps the old value, that the halt request rises, that no conversion begins, and that the held value appears once the read ends.

// File: rtl/cbif_pkg.sv
package cbif_pkg;

  // Latch load strobes passed from control to datapath
  typedef struct packed {
    logic capDirect;   // load the sequencer result straight into the output latch
    logic capShadow;   // park the sequencer result while a read blocks the latch
    logic fromShadow;  // move the parked result into the output latch
  } latchStrb_t;

endpackage

// File: rtl/cbif_ctrl.sv
module cbif_ctrl
  import cbif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       modeSel,
  input  logic       seqBusy,
  output logic       startPulse,
  output logic       haltReq,
  output logic       dataOe,
  output latchStrb_t strb
);

  localparam int GUARD_LOAD = GUARD_CYC + SYNC_STAGES;
  localparam int GW         = $clog2(GUARD_LOAD + 1);

  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] rdPipe;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            csPipe[s] <= 1'b1;
            rdPipe[s] <= 1'b1;
          end else begin
            csPipe[s] <= csN;
            rdPipe[s] <= rdN;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            csPipe[s] <= 1'b1;
            rdPipe[s] <= 1'b1;
          end else begin
            csPipe[s] <= csPipe[s-1];
            rdPipe[s] <= rdPipe[s-1];
          end
        end
      end
    end
  endgenerate

  logic          selNow, selPrev, selFall;
  logic          busyPrev, eoc;
  logic [GW-1:0] guardCnt;
  logic          guardOpen;
  logic          launched, seqIdle;
  logic          pendUpd, deferNow;
  logic          swGo, frGo, startQ;

  assign selNow    = !csPipe[SYNC_STAGES-1] && !rdPipe[SYNC_STAGES-1];
  assign selFall   = selNow && !selPrev;
  assign eoc       = busyPrev && !seqBusy;
  assign guardOpen = eoc || (guardCnt != '0);
  assign seqIdle   = !seqBusy && !launched && !startQ;
  assign deferNow  = eoc && !modeSel && selNow;
  assign swGo      = modeSel && selFall && seqIdle && !guardOpen;
  assign frGo      = !modeSel && seqIdle && !pendUpd && !deferNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev  <= 1'b0;
      busyPrev <= 1'b0;
      guardCnt <= '0;
      launched <= 1'b0;
      pendUpd  <= 1'b0;
      startQ   <= 1'b0;
    end else begin
      selPrev  <= selNow;
      busyPrev <= seqBusy;
      if (eoc)                 guardCnt <= GW'(GUARD_LOAD);
      else if (guardCnt != '0) guardCnt <= guardCnt - 1'b1;
      if (seqBusy)             launched <= 1'b0;
      else if (startQ)         launched <= 1'b1;
      if (deferNow)                pendUpd <= 1'b1;
      else if (pendUpd && !selNow) pendUpd <= 1'b0;
      startQ <= swGo || frGo;
    end
  end

  assign startPulse      = startQ;
  assign haltReq         = pendUpd;
  assign dataOe          = !csN && !rdN;
  assign strb.capDirect  = eoc && !deferNow;
  assign strb.capShadow  = deferNow;
  assign strb.fromShadow = pendUpd && !selNow;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);  // R4
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !$past(seqBusy));  // R4
  AST_GUARD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && guardOpen) |=> !startPulse);  // R7
  AST_WAIT_NO_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && eoc && !haltReq) |=> !haltReq);  // R5
  AST_HALT_BLOCKS_START: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> !startPulse);  // R9
  AST_NO_DIRECT_WHILE_PEND: assert property (@(posedge clk) disable iff (!rstN)
    pendUpd |-> !strb.capDirect);  // R9

endmodule

// File: rtl/cbif_dpath.sv
module cbif_dpath
  import cbif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  latchStrb_t        strb,
  input  logic [DATA_W-1:0] seqResult,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] shadowReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowReg <= '0;
      dataReg   <= '0;
    end else begin
      if (strb.capShadow) shadowReg <= seqResult;
      if (strb.capDirect)       dataReg <= seqResult;
      else if (strb.fromShadow) dataReg <= shadowReg;
    end
  end

  assign dataOut = dataReg;

  AST_STRB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capDirect, strb.capShadow, strb.fromShadow}));  // R9

endmodule

// File: rtl/conv_bus_if.sv
module conv_bus_if
  import cbif_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              modeSel,
  input  logic              seqBusy,
  input  logic [DATA_W-1:0] seqResult,
  output logic              startPulse,
  output logic              haltReq,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  latchStrb_t strb;

  cbif_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .GUARD_CYC  (GUARD_CYC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .rdN       (rdN),
    .modeSel   (modeSel),
    .seqBusy   (seqBusy),
    .startPulse(startPulse),
    .haltReq   (haltReq),
    .dataOe    (dataOe),
    .strb      (strb)
  );

  cbif_dpath #(
    .DATA_W(DATA_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .seqResult(seqResult),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/sim_conv_bus_if.sv
module sim_conv_bus_if;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_CYC   = 6;
  localparam int NVEC       = 6;
  localparam logic [7:0] CONV_VALS [0:NVEC-1] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h7E};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       rdN = 1'b1;
  logic       modeSel = 1'b1;
  logic       seqBusy = 1'b0;
  logic [7:0] seqResult = 8'h00;
  logic       startPulse, haltReq, dataOe;
  logic [7:0] dataOut;

  logic [7:0] nextResult = 8'h00;
  logic       autoInc = 1'b0;
  int         startCount = 0;
  int         hiSamples = 0;
  int         rises = 0;
  int         total = 0;
  int         bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_bus_if u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .modeSel(modeSel),
    .seqBusy(seqBusy), .seqResult(seqResult), .startPulse(startPulse),
    .haltReq(haltReq), .dataOut(dataOut), .dataOe(dataOe)
  );

  // Sequencer model: answers a start pulse with CONV_CYC busy cycles
  initial begin : seqModel
    int cnt;
    logic prevP;
    logic [7:0] freeVal;
    cnt = 0;
    prevP = 1'b0;
    freeVal = 8'h40;
    forever begin
      @(negedge clk);
      if (startPulse === 1'b1) begin
        hiSamples++;
        if (!prevP) rises++;
      end
      prevP = (startPulse === 1'b1);
      if (startPulse === 1'b1 && !seqBusy) begin
        seqBusy = 1'b1;
        cnt = CONV_CYC;
        startCount++;
      end else if (seqBusy) begin
        cnt--;
        if (cnt == 0) begin
          seqBusy = 1'b0;
          if (autoInc) begin
            freeVal = freeVal + 8'd1;
            seqResult = freeVal;
          end else begin
            seqResult = nextResult;
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitBusyRise();
    for (int g = 0; g < 200 && !seqBusy; g++) tick(1);
  endtask

  task automatic waitBusyFall();
    for (int g = 0; g < 200 && seqBusy; g++) tick(1);
  endtask

  task automatic selLow();
    csN = 1'b0;
    rdN = 1'b0;
  endtask

  task automatic selHigh();
    csN = 1'b1;
    rdN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : mainSeq
    logic [7:0] prevVal;
    logic [7:0] oldVal;
    int s0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    check("R1 dataOe", dataOe, 0);
    check("R1 startPulse", startPulse, 0);
    check("R1 haltReq", haltReq, 0);
    check("R1 dataOut", dataOut, 0);

    // R2: a single strobe does nothing
    s0 = startCount;
    rdN = 1'b0;
    tick(1);
    check("R2 oe rd only", dataOe, 0);
    tick(6);
    check("R2 no start rd only", startCount, s0);
    rdN = 1'b1;
    csN = 1'b0;
    tick(7);
    check("R2 oe cs only", dataOe, 0);
    check("R2 no start cs only", startCount, s0);
    csN = 1'b1;
    tick(3);

    // Vector table: wait-state reads in software-started mode
    prevVal = 8'h00;
    for (int i = 0; i < NVEC; i++) begin
      nextResult = CONV_VALS[i];
      s0 = startCount;
      selLow();
      #1;
      check("R2 oe on", dataOe, 1);
      check("R6 old data at read", dataOut, prevVal);
      waitBusyRise();
      waitBusyFall();
      tick(1);
      check("R5 new data held read", dataOut, CONV_VALS[i]);
      check("R5 no halt", haltReq, 0);
      check("R3 one start", startCount, s0 + 1);
      selHigh();
      #1;
      check("R2 oe off", dataOe, 0);
      tick(5);
      prevVal = CONV_VALS[i];
    end

    // R6: read during conversion returns the previous result, starts nothing
    nextResult = 8'h5A;
    s0 = startCount;
    selLow();
    tick(3);
    selHigh();
    waitBusyRise();
    tick(2);
    selLow();
    tick(1);
    check("R6 old data mid conv", dataOut, prevVal);
    tick(3);
    check("R6 no start mid conv", startCount, s0 + 1);
    selHigh();
    waitBusyFall();
    tick(1);
    check("R5 non-wait update", dataOut, 8'h5A);
    tick(5);

    // R7 case A: strobes low at the end-of-conversion edge
    nextResult = 8'h11;
    selLow(); tick(3); selHigh();
    waitBusyFall();
    s0 = startCount;
    selLow();
    tick(10);
    check("R7 suppressed same edge", startCount, s0);
    check("R7 data new A", dataOut, 8'h11);
    selHigh();
    tick(5);

    // R7 case B: strobes low one clock later
    nextResult = 8'h22;
    selLow(); tick(3); selHigh();
    waitBusyFall();
    tick(1);
    s0 = startCount;
    selLow();
    tick(10);
    check("R7 suppressed one later", startCount, s0);
    check("R7 data new B", dataOut, 8'h22);
    selHigh();
    tick(5);

    // R7 case C: strobes low two clocks later start again
    nextResult = 8'h33;
    selLow(); tick(3); selHigh();
    waitBusyFall();
    tick(2);
    s0 = startCount;
    selLow();
    tick(6);
    check("R7 start two later", startCount, s0 + 1);
    selHigh();
    waitBusyFall();
    tick(3);

    // R8: free-running conversions
    autoInc = 1'b1;
    s0 = startCount;
    modeSel = 1'b0;
    tick(40);
    check("R8 back to back", (startCount - s0 >= 4), 1);
    waitBusyFall();
    tick(1);
    check("R8 latch follows", dataOut, seqResult);

    // R9: read held across end of conversion defers the update
    waitBusyRise();
    oldVal = seqResult;
    selLow();
    tick(1);
    check("R9 old during read", dataOut, oldVal);
    waitBusyFall();
    tick(1);
    check("R9 halt raised", haltReq, 1);
    check("R9 latch kept", dataOut, oldVal);
    s0 = startCount;
    tick(8);
    check("R9 no start while held", startCount, s0);
    check("R9 still halted", haltReq, 1);
    check("R9 still old", dataOut, oldVal);
    selHigh();
    tick(4);
    check("R9 held result loaded", dataOut, seqResult);
    check("R9 halt released", haltReq, 0);
    tick(4);
    check("R9 resumed", (startCount > s0), 1);

    // R4: every start pulse was one clock wide
    check("R4 pulse width", hiSamples, rises);
    check("R4 pulses seen", (rises == startCount), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule